// File: doc/BRIEF.md
# Two-Wire Control Register Slave

This block is a slave on a two-wire serial bus. Through it an external master reads and writes a bank of seventeen 8-bit control registers, numbered 00h to 10h. Both bus lines are brought into the system clock domain, and start, repeated start and stop conditions are detected there. After a start, the block compares the first byte with its fixed 7-bit device address. In write mode the next byte is taken as a base register number. Each data byte after that is stored at the current register and moves the register pointer forward. The master can then issue a repeated start with the read bit set and stream register contents back, beginning at the base it last stored.

The data line is open drain. The block never drives it high. It asserts an output enable that pulls the line low, and it watches the resolved level on a separate input. The whole register bank is also available in parallel so that the surrounding logic can use the settings directly.

Top module: `regbank_i2c_slave`

## Requirements
- R1: After reset every register reads 00h, the stored base register number is 00h, and the data line is released (`sda_oe` low).
- R2: In a write transfer the first byte after a matching device address sets the base register number. The data byte that follows is stored in that register. The block acknowledges each of these bytes by pulling the data line low during the ninth clock.
- R3: Every byte on the bus is shifted most significant bit first, whether it is an address or data and whichever way it travels.
- R4: Each further data byte in a write goes to the next register up. The pointer increases by one after every stored byte.
- R5: Once the pointer reaches 10h it stays there, for writes and for reads. Extra write bytes overwrite register 10h, and extra read bytes repeat its contents.
- R6: A base register number above 10h gets no acknowledge. The data bytes that follow are then not acknowledged and change no register.
- R7: The device address is the upper seven bits of the first byte, and its lowest bit is the read flag (1 = read). If those seven bits do not equal the configured address, the byte gets no acknowledge and the block ignores the bus until the next start or stop.
- R8: After a repeated start with the read flag set, the block acknowledges its address and then sends the register at the stored base, followed by the registers above it.
- R9: If the master does not acknowledge a byte during a read, the block ends the read. It keeps the data line released until the next start or stop.
- R10: A stop (data rising while the clock is high) releases the data line and returns the block to idle. A byte cut short by a stop is discarded.
- R11: The block changes its drive on the data line only while the clock line is low.
- R12: A read begins at the base register number most recently stored, even if later write bytes have moved the pointer past it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Serial clock line level |
| sda_i | input | 1 | Resolved serial data line level |
| sda_oe | output | 1 | When high, pulls the data line low |
| regs_o | output | 136 | Parallel view of the registers; register n occupies bits 8n+7 down to 8n |

## Verification
The bench pushes the pointer to 10h in both directions. A design that wraps or overflows there would write register 00h or return unrelated contents. A base of 11h, a foreign device address and a byte cut short by a stop must all leave the register bank unchanged and get no acknowledge. A slave that stays attached after refusing a byte would store the stray data. The read tests use a base that differs from where the previous write left the pointer, and they end with a master NACK followed by an extra byte of clocks. This catches a slave that reads from the write pointer or keeps driving after the NACK.

// File: rtl/regbank_i2c_slave.sv
module regbank_i2c_slave #(
  parameter logic [6:0] DEV_ADDR = 7'h2A,
  parameter int LAST_REG = 16,
  parameter int SYNC_FF = 2
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      scl_i,
  input  logic                      sda_i,
  output logic                      sda_oe,
  output logic [(LAST_REG+1)*8-1:0] regs_o
);
  localparam int NREG = LAST_REG + 1;
  localparam int PW = $clog2(NREG);
  localparam logic [7:0] LAST_B = 8'(LAST_REG);
  localparam logic [PW-1:0] LAST_P = PW'(LAST_REG);

  typedef enum logic [2:0] {S_IDLE, S_DEV, S_PTR, S_WR, S_RD} state_t;

  logic [SYNC_FF-1:0] scl_sy, sda_sy;
  logic scl_q, sda_q;
  logic scl_s, sda_s;
  logic start_det, stop_det, scl_rise, scl_fall;

  state_t state;
  logic [3:0] cnt;
  logic [7:0] shreg, tx_sh;
  logic [PW-1:0] ptr, base;
  logic ack_oe, tx_en, rd_mode, m_ack;
  logic [7:0] regs [NREG];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      scl_sy <= '1; sda_sy <= '1; scl_q <= 1'b1; sda_q <= 1'b1;
    end else begin
      scl_sy <= {scl_sy[SYNC_FF-2:0], scl_i};
      sda_sy <= {sda_sy[SYNC_FF-2:0], sda_i};
      scl_q <= scl_s;
      sda_q <= sda_s;
    end

  assign scl_s = scl_sy[SYNC_FF-1];
  assign sda_s = sda_sy[SYNC_FF-1];
  assign start_det = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_det = scl_s & scl_q & ~sda_q & sda_s;
  assign scl_rise = scl_s & ~scl_q;
  assign scl_fall = ~scl_s & scl_q;
  assign sda_oe = ack_oe | (tx_en & ~tx_sh[7]);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      state <= S_IDLE; cnt <= '0; shreg <= '0; tx_sh <= '0;
      ptr <= '0; base <= '0;
      ack_oe <= 1'b0; tx_en <= 1'b0; rd_mode <= 1'b0; m_ack <= 1'b0;
      for (int i = 0; i < NREG; i++) regs[i] <= '0;
    end else if (start_det) begin
      state <= S_DEV; cnt <= '0; ack_oe <= 1'b0; tx_en <= 1'b0;
    end else if (stop_det) begin
      state <= S_IDLE; cnt <= '0; ack_oe <= 1'b0; tx_en <= 1'b0;
    end else if (state != S_IDLE) begin
      if (scl_rise) begin
        if (cnt < 4'd8) begin
          cnt <= cnt + 4'd1;
          if (state != S_RD) shreg <= {shreg[6:0], sda_s};
        end else if (cnt == 4'd8) begin
          cnt <= 4'd9;
          m_ack <= ~sda_s;
        end
      end else if (scl_fall) begin
        if (state == S_RD) begin
          if (cnt >= 4'd1 && cnt <= 4'd7) tx_sh <= {tx_sh[6:0], 1'b0};
          else if (cnt == 4'd8) begin
            tx_en <= 1'b0;
            if (ptr != LAST_P) ptr <= ptr + 1'b1;
          end else if (cnt == 4'd9) begin
            cnt <= '0;
            if (m_ack) begin
              tx_sh <= regs[ptr];
              tx_en <= 1'b1;
            end else state <= S_IDLE;
          end
        end else if (cnt == 4'd8) begin
          case (state)
            S_DEV:
              if (shreg[7:1] == DEV_ADDR) begin
                ack_oe <= 1'b1;
                rd_mode <= shreg[0];
              end else state <= S_IDLE;
            S_PTR:
              if (shreg <= LAST_B) begin
                ack_oe <= 1'b1;
                base <= shreg[PW-1:0];
                ptr <= shreg[PW-1:0];
              end else state <= S_IDLE;
            default: begin
              ack_oe <= 1'b1;
              regs[ptr] <= shreg;
              if (ptr != LAST_P) ptr <= ptr + 1'b1;
            end
          endcase
        end else if (cnt == 4'd9) begin
          ack_oe <= 1'b0;
          cnt <= '0;
          if (state == S_DEV) begin
            if (rd_mode) begin
              state <= S_RD;
              ptr <= base;
              tx_sh <= regs[base];
              tx_en <= 1'b1;
            end else state <= S_PTR;
          end else if (state == S_PTR) state <= S_WR;
        end
      end
    end

  for (genvar g = 0; g < NREG; g++) begin : g_view
    assign regs_o[8*g +: 8] = regs[g];
  end
endmodule

// File: rtl/regbank_i2c_slave_chk.sv
module regbank_i2c_slave_chk #(
  parameter int LAST_REG = 16
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic                      scl_i,
  input logic                      sda_oe,
  input logic                      stop_det,
  input logic [$clog2(LAST_REG+1)-1:0] ptr,
  input logic [(LAST_REG+1)*8-1:0] regs_o
);
  localparam int PW = $clog2(LAST_REG + 1);
  localparam logic [PW-1:0] LAST_P = PW'(LAST_REG);

  assert_drive_scl_low_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe) |-> !scl_i);

  assert_write_acked_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(regs_o) |-> sda_oe);

  assert_ptr_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(regs_o) && $past(ptr) == LAST_P) |-> ptr == LAST_P);

  assert_stop_release_R10: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> !sda_oe);
endmodule

bind regbank_i2c_slave regbank_i2c_slave_chk #(.LAST_REG(LAST_REG)) u_chk (
  .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_oe(sda_oe),
  .stop_det(stop_det), .ptr(ptr), .regs_o(regs_o)
);

// File: tb/regbank_i2c_slave_test.sv
module regbank_i2c_slave_test;
  localparam int CLK_PERIOD = 10;
  localparam int Q = 8;
  localparam logic [6:0] ADDR = 7'h2A;

  logic clk = 1'b0, rst_n = 1'b0;
  logic scl = 1'b1, sda_m = 1'b1;
  logic sda_oe;
  logic [135:0] regs_o;
  logic sda_line;
  int n_chk = 0, n_bad = 0;

  assign sda_line = sda_m & ~sda_oe;
  always #(CLK_PERIOD/2) clk = ~clk;

  regbank_i2c_slave uut (.clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_line),
                         .sda_oe(sda_oe), .regs_o(regs_o));

  task automatic qw(); repeat (Q) @(posedge clk); #1; endtask

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int rg(input int i); return int'(regs_o[8*i +: 8]); endfunction

  task automatic bstart(); sda_m = 1; qw(); scl = 1; qw(); sda_m = 0; qw(); scl = 0; qw(); endtask
  task automatic bstop(); sda_m = 0; qw(); scl = 1; qw(); sda_m = 1; qw(); qw(); endtask

  task automatic sbyte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; qw(); scl = 1; qw(); qw(); scl = 0; qw();
    end
    sda_m = 1; qw(); scl = 1; qw(); ack = ~sda_line; qw(); scl = 0; qw();
  endtask

  task automatic rbyte(input logic nack, output logic [7:0] b);
    sda_m = 1;
    for (int i = 7; i >= 0; i--) begin
      qw(); scl = 1; qw(); b[i] = sda_line; qw(); scl = 0;
    end
    qw(); sda_m = nack; qw(); scl = 1; qw(); qw(); scl = 0; qw(); sda_m = 1;
  endtask

  task automatic t_reset();
    chk("R1 regs", int'(regs_o == '0), 1);
    chk("R1 sda_oe", sda_oe, 0);
  endtask

  task automatic t_single();
    logic a;
    bstart();
    sbyte({ADDR, 1'b0}, a); chk("R2 dev ack", a, 1);
    sbyte(8'h03, a); chk("R2 base ack", a, 1);
    sbyte(8'hA5, a); chk("R2 data ack", a, 1);
    bstop();
    chk("R2 R3 reg3", rg(3), 8'hA5);
    chk("R10 released", sda_oe, 0);
  endtask

  task automatic t_burst();
    logic a;
    bstart(); sbyte({ADDR, 1'b0}, a); sbyte(8'h05, a);
    sbyte(8'h11, a); sbyte(8'h22, a); sbyte(8'h3C, a); sbyte(8'h81, a);
    bstop();
    chk("R4 reg5", rg(5), 8'h11);
    chk("R4 reg6", rg(6), 8'h22);
    chk("R4 R3 reg7", rg(7), 8'h3C);
    chk("R4 R3 reg8", rg(8), 8'h81);
  endtask

  task automatic t_saturate();
    logic a;
    bstart(); sbyte({ADDR, 1'b0}, a); sbyte(8'h0F, a);
    sbyte(8'h5A, a); sbyte(8'hC3, a); sbyte(8'h7E, a);
    chk("R5 ack at top", a, 1);
    bstop();
    chk("R5 regF", rg(15), 8'h5A);
    chk("R5 reg10", rg(16), 8'h7E);
    chk("R5 reg0 untouched", rg(0), 0);
  endtask

  task automatic t_bad_base();
    logic a;
    logic [135:0] snap;
    snap = regs_o;
    bstart(); sbyte({ADDR, 1'b0}, a); sbyte(8'h11, a);
    chk("R6 base nack", a, 0);
    sbyte(8'hFF, a); chk("R6 data nack", a, 0);
    bstop();
    chk("R6 regs unchanged", int'(regs_o == snap), 1);
  endtask

  task automatic t_bad_addr();
    logic a;
    logic [135:0] snap;
    snap = regs_o;
    bstart(); sbyte({7'h2B, 1'b0}, a);
    chk("R7 addr nack", a, 0);
    sbyte(8'h02, a); chk("R7 ignored nack", a, 0);
    sbyte(8'h99, a);
    bstop();
    chk("R7 regs unchanged", int'(regs_o == snap), 1);
  endtask

  task automatic t_read();
    logic a;
    logic [7:0] b;
    bstart(); sbyte({ADDR, 1'b0}, a); sbyte(8'h05, a);
    bstart(); sbyte({ADDR, 1'b1}, a); chk("R8 read addr ack", a, 1);
    rbyte(1'b0, b); chk("R8 R3 first", b, 8'h11);
    rbyte(1'b0, b); chk("R8 second", b, 8'h22);
    rbyte(1'b1, b); chk("R8 third", b, 8'h3C);
    rbyte(1'b1, b); chk("R9 released after nack", b, 8'hFF);
    bstop();
  endtask

  task automatic t_read_base();
    logic a;
    logic [7:0] b;
    bstart(); sbyte({ADDR, 1'b0}, a); sbyte(8'h02, a);
    sbyte(8'h77, a); sbyte(8'h88, a);
    bstart(); sbyte({ADDR, 1'b1}, a);
    rbyte(1'b0, b); chk("R12 starts at base", b, 8'h77);
    rbyte(1'b1, b); chk("R12 next", b, 8'h88);
    bstop();
    bstart(); sbyte({ADDR, 1'b0}, a); sbyte(8'h10, a);
    bstart(); sbyte({ADDR, 1'b1}, a);
    rbyte(1'b0, b); chk("R5 read top", b, 8'h7E);
    rbyte(1'b1, b); chk("R5 read holds", b, 8'h7E);
    bstop();
  endtask

  task automatic t_stop_mid();
    logic a;
    bstart(); sbyte({ADDR, 1'b0}, a); sbyte(8'h01, a);
    for (int i = 0; i < 4; i++) begin
      sda_m = 1; qw(); scl = 1; qw(); qw(); scl = 0; qw();
    end
    bstop();
    chk("R10 partial discarded", rg(1), 0);
    chk("R10 sda released", sda_oe, 0);
    bstart(); sbyte({ADDR, 1'b0}, a); sbyte(8'h01, a); sbyte(8'h42, a); bstop();
    chk("R10 next transfer", rg(1), 8'h42);
  endtask

  initial begin
    repeat (5) @(posedge clk);
    #1 rst_n = 1'b1;
    qw();
    t_reset();
    t_single();
    t_burst();
    t_saturate();
    t_bad_base();
    t_bad_addr();
    t_read();
    t_read_base();
    t_stop_mid();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule